// File: doc/BRIEF.md
# Software-Refilled Tagged Translation Buffer

This block translates 32-bit virtual addresses for a processor that has no hardware page-table walker. Each lookup presents a virtual address, an access type and a privilege mode. The block compares them against 64 tagged entries searched in parallel. It returns one of three results: a physical address, a miss trap that carries the faulting address, or a protection fault. Pages are 4 KB. The 20-bit page number is translated and the 12-bit offset passes through unchanged.

Entries are loaded only by software, through an indexed write port. One flush command invalidates every entry at once. Each entry carries a 6-bit address-space tag that must equal the current-tag register, so entries stay valid across context switches. A supervisor-only window, selected by the top three address bits being 3'b100, is translated without any entry. It serves the resident kernel.

Top module: `soft_tlb`

## Requirements
- R1: After reset every entry is invalid and the current-tag register is 0, so any lookup outside the window misses.
- R2: A lookup hits when a valid entry's page number equals va[31:12] and its tag equals the current-tag register; pa_o is then {frame, va[11:0]}.
- R3: An entry whose tag differs from the current-tag register does not match; a write to the current-tag register (asid_we_i) takes effect from the next cycle.
- R4: When no entry matches outside the window, miss_o is set and trap_va_o equals the lookup address; a miss never loads an entry, so a repeated lookup misses again.
- R5: Permission bits are [0] supervisor read, [1] supervisor write, [2] supervisor execute, [3] user read, [4] user write, [5] user execute; access codes are 0 read, 1 write, 2 execute. A matching entry that lacks the bit for the mode and access raises fault_o. Access code 3 always faults on a matching entry.
- R6: A supervisor lookup (sup_i=1) with va[31:29]==3'b100 hits without any entry, with pa_o equal to va with bits [31:29] cleared.
- R7: A user lookup (sup_i=0) with va[31:29]==3'b100 raises fault_o.
- R8: An entry write (index, page number, tag, frame, permissions, valid bit) is visible from the next cycle; a lookup in the same cycle sees the old contents.
- R9: flush_i clears every valid bit in one cycle and has priority over an entry write in the same cycle, which is dropped.
- R10: When several entries match, the lowest-numbered one supplies the frame and permissions.
- R11: hit_o, miss_o and fault_o are one-hot when lk_valid_i is 1 and all 0 when it is 0; pa_o is 0 unless hit_o is set, and trap_va_o is 0 unless miss_o or fault_o is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lk_valid_i | input | 1 | Lookup request |
| lk_va_i | input | 32 | Lookup virtual address |
| lk_acc_i | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| lk_sup_i | input | 1 | 1 for supervisor mode, 0 for user mode |
| asid_we_i | input | 1 | Load the current-tag register |
| asid_i | input | 6 | New current tag |
| wr_en_i | input | 1 | Entry write strobe |
| wr_idx_i | input | 6 | Entry index |
| wr_vpn_i | input | 20 | Page number to store |
| wr_asid_i | input | 6 | Tag to store |
| wr_pfn_i | input | 20 | Frame number to store |
| wr_perm_i | input | 6 | Permission bits |
| wr_valid_i | input | 1 | Valid bit to store |
| flush_i | input | 1 | Invalidate all entries |
| hit_o | output | 1 | Translation returned |
| miss_o | output | 1 | Miss trap |
| fault_o | output | 1 | Protection fault |
| pa_o | output | 32 | Physical address |
| trap_va_o | output | 32 | Faulting virtual address |

## Verification
The bench fills entries from a small pool of page numbers and tags, so duplicate matches and tag mismatches happen often. A priority encoder that picks the highest index instead of the lowest returns the wrong frame. Directed cases cover the following corner cases and the failure each one exposes:
- A lookup in the same cycle as its write. A bypassing design would hit a cycle early.
- A flush together with a write. A design that lets the write win would leave one live entry.
- User access to the kernel window. A mode-blind decoder would return an address instead of faulting.
- The reserved access code. A design that indexes the permission vector with it would read a bit that belongs to another mode.

// File: rtl/soft_tlb_pkg.sv
package soft_tlb_pkg;
  localparam int PERM_W = 6;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  // perm layout: [2:0] supervisor r/w/x, [5:3] user r/w/x
  function automatic logic perm_allows(input logic [PERM_W-1:0] perm,
                                       input logic sup,
                                       input logic [1:0] acc);
    logic [2:0] idx;
    if (acc == ACC_RSVD) return 1'b0;
    idx = (sup ? 3'd0 : 3'd3) + {1'b0, acc};
    return perm[idx];
  endfunction
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
  parameter int N      = 64,
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 20,
  parameter int ASID_W = 6,
  parameter int PERM_W = 6,
  localparam int IDX_W = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [VPN_W-1:0]  wr_vpn_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic [PFN_W-1:0]  wr_pfn_i,
  input  logic [PERM_W-1:0] wr_perm_i,
  input  logic              wr_valid_i,
  input  logic              flush_i,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  input  logic [ASID_W-1:0] cur_asid_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [N-1:0]      match_o,
  output logic [PFN_W-1:0]  rd_pfn_o,
  output logic [PERM_W-1:0] rd_perm_o
);
  logic [N-1:0]      valid_q;
  logic [VPN_W-1:0]  vpn_q  [N];
  logic [ASID_W-1:0] asid_q [N];
  logic [PFN_W-1:0]  pfn_q  [N];
  logic [PERM_W-1:0] perm_q [N];

  wire do_write = wr_en_i && !flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else if (flush_i) begin
      valid_q <= '0;
    end else if (wr_en_i) begin
      valid_q[wr_idx_i] <= wr_valid_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_write) begin
      vpn_q[wr_idx_i]  <= wr_vpn_i;
      asid_q[wr_idx_i] <= wr_asid_i;
      pfn_q[wr_idx_i]  <= wr_pfn_i;
      perm_q[wr_idx_i] <= wr_perm_i;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_o[g] = valid_q[g] && (vpn_q[g] == lk_vpn_i) && (asid_q[g] == cur_asid_i);
  end

  assign rd_pfn_o  = pfn_q[rd_idx_i];
  assign rd_perm_o = perm_q[rd_idx_i];

  p_flush_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_q == '0));

  p_write_lands_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_write |=> (vpn_q[$past(wr_idx_i)] == $past(wr_vpn_i)) &&
                 (valid_q[$past(wr_idx_i)] == $past(wr_valid_i)));
endmodule

// File: rtl/tlb_prio_pick.sv
module tlb_prio_pick #(
  parameter int N = 64,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     match_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |match_i;
endmodule

// File: rtl/tlb_access_decide.sv
module tlb_access_decide
  import soft_tlb_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int WIN_BITS  = 3,
  parameter logic [WIN_BITS-1:0] WIN_TAG = 3'b100,
  localparam int PFN_W = VA_W - PAGE_BITS
) (
  input  logic              lk_valid_i,
  input  logic [VA_W-1:0]   lk_va_i,
  input  logic [1:0]        lk_acc_i,
  input  logic              lk_sup_i,
  input  logic              any_i,
  input  logic [PFN_W-1:0]  pfn_i,
  input  logic [PERM_W-1:0] perm_i,
  output logic              hit_o,
  output logic              miss_o,
  output logic              fault_o,
  output logic [VA_W-1:0]   pa_o,
  output logic [VA_W-1:0]   trap_va_o
);
  wire in_win = (lk_va_i[VA_W-1 -: WIN_BITS] == WIN_TAG);

  always_comb begin
    hit_o   = 1'b0;
    miss_o  = 1'b0;
    fault_o = 1'b0;
    pa_o    = '0;
    if (lk_valid_i) begin
      if (in_win) begin
        if (lk_sup_i) begin
          hit_o = 1'b1;
          pa_o  = {{WIN_BITS{1'b0}}, lk_va_i[VA_W-WIN_BITS-1:0]};
        end else begin
          fault_o = 1'b1;
        end
      end else if (!any_i) begin
        miss_o = 1'b1;
      end else if (perm_allows(perm_i, lk_sup_i, lk_acc_i)) begin
        hit_o = 1'b1;
        pa_o  = {pfn_i, lk_va_i[PAGE_BITS-1:0]};
      end else begin
        fault_o = 1'b1;
      end
    end
    trap_va_o = (miss_o || fault_o) ? lk_va_i : '0;
  end
endmodule

// File: rtl/soft_tlb.sv
module soft_tlb
  import soft_tlb_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int ENTRIES   = 64,
  parameter int ASID_W    = 6,
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic [VA_W-1:0]   lk_va_i,
  input  logic [1:0]        lk_acc_i,
  input  logic              lk_sup_i,
  input  logic              asid_we_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [VPN_W-1:0]  wr_vpn_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic [VPN_W-1:0]  wr_pfn_i,
  input  logic [PERM_W-1:0] wr_perm_i,
  input  logic              wr_valid_i,
  input  logic              flush_i,
  output logic              hit_o,
  output logic              miss_o,
  output logic              fault_o,
  output logic [VA_W-1:0]   pa_o,
  output logic [VA_W-1:0]   trap_va_o
);
  logic [ASID_W-1:0]  cur_asid_q;
  logic [ENTRIES-1:0] match;
  logic               any_match;
  logic [IDX_W-1:0]   sel_idx;
  logic [VPN_W-1:0]   sel_pfn;
  logic [PERM_W-1:0]  sel_perm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cur_asid_q <= '0;
    else if (asid_we_i) cur_asid_q <= asid_i;
  end

  tlb_entry_store #(
    .N(ENTRIES), .VPN_W(VPN_W), .PFN_W(VPN_W), .ASID_W(ASID_W), .PERM_W(PERM_W)
  ) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_idx_i   (wr_idx_i),
    .wr_vpn_i   (wr_vpn_i),
    .wr_asid_i  (wr_asid_i),
    .wr_pfn_i   (wr_pfn_i),
    .wr_perm_i  (wr_perm_i),
    .wr_valid_i (wr_valid_i),
    .flush_i    (flush_i),
    .lk_vpn_i   (lk_va_i[VA_W-1:PAGE_BITS]),
    .cur_asid_i (cur_asid_q),
    .rd_idx_i   (sel_idx),
    .match_o    (match),
    .rd_pfn_o   (sel_pfn),
    .rd_perm_o  (sel_perm)
  );

  tlb_prio_pick #(.N(ENTRIES)) u_pick (
    .match_i (match),
    .any_o   (any_match),
    .idx_o   (sel_idx)
  );

  tlb_access_decide #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS)) u_decide (
    .lk_valid_i (lk_valid_i),
    .lk_va_i    (lk_va_i),
    .lk_acc_i   (lk_acc_i),
    .lk_sup_i   (lk_sup_i),
    .any_i      (any_match),
    .pfn_i      (sel_pfn),
    .perm_i     (sel_perm),
    .hit_o      (hit_o),
    .miss_o     (miss_o),
    .fault_o    (fault_o),
    .pa_o       (pa_o),
    .trap_va_o  (trap_va_o)
  );

  wire in_win = (lk_va_i[VA_W-1 -: 3] == 3'b100);

  p_onehot_result_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |-> $onehot({hit_o, miss_o, fault_o}));

  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |-> !(hit_o || miss_o || fault_o));

  p_win_never_miss_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && in_win && lk_sup_i) |-> (hit_o && pa_o[VA_W-1 -: 3] == 3'b000));

  p_win_user_fault_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && in_win && !lk_sup_i) |-> fault_o);

  p_miss_reports_va_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> (trap_va_o == lk_va_i && !any_match));

  p_offset_passes_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !in_win) |-> (pa_o[PAGE_BITS-1:0] == lk_va_i[PAGE_BITS-1:0]));
endmodule

// File: tb/soft_tlb_tb.sv
module soft_tlb_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lk_valid = 0;
  logic [31:0] lk_va = 0;
  logic [1:0]  lk_acc = 0;
  logic        lk_sup = 0;
  logic        asid_we = 0;
  logic [5:0]  asid_in = 0;
  logic        wr_en = 0;
  logic [5:0]  wr_idx = 0;
  logic [19:0] wr_vpn = 0;
  logic [5:0]  wr_asid = 0;
  logic [19:0] wr_pfn = 0;
  logic [5:0]  wr_perm = 0;
  logic        wr_valid = 0;
  logic        flush = 0;
  logic        hit, miss, fault;
  logic [31:0] pa, trap_va;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic        m_val  [64];
  logic [19:0] m_vpn  [64];
  logic [5:0]  m_asid [64];
  logic [19:0] m_pfn  [64];
  logic [5:0]  m_perm [64];
  logic [5:0]  m_cur;

  always #4 clk = ~clk;

  soft_tlb u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .lk_valid_i(lk_valid), .lk_va_i(lk_va), .lk_acc_i(lk_acc), .lk_sup_i(lk_sup),
    .asid_we_i(asid_we), .asid_i(asid_in),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_vpn_i(wr_vpn), .wr_asid_i(wr_asid),
    .wr_pfn_i(wr_pfn), .wr_perm_i(wr_perm), .wr_valid_i(wr_valid), .flush_i(flush),
    .hit_o(hit), .miss_o(miss), .fault_o(fault), .pa_o(pa), .trap_va_o(trap_va)
  );

  task automatic model_lookup(output logic h, output logic m, output logic f,
                              output logic [31:0] p, output logic [31:0] t);
    int found;
    int pidx;
    h = 0; m = 0; f = 0; p = 0; t = 0;
    if (lk_valid) begin
      if (lk_va[31:29] == 3'b100) begin
        if (lk_sup) begin h = 1; p = {3'b000, lk_va[28:0]}; end
        else f = 1;
      end else begin
        found = -1;
        for (int i = 63; i >= 0; i--)
          if (m_val[i] && m_vpn[i] == lk_va[31:12] && m_asid[i] == m_cur) found = i;
        if (found < 0) m = 1;
        else begin
          pidx = (lk_sup ? 0 : 3) + int'(lk_acc);
          if (lk_acc != 2'b11 && m_perm[found][pidx]) begin
            h = 1; p = {m_pfn[found], lk_va[11:0]};
          end else f = 1;
        end
      end
      if (m || f) t = lk_va;
    end
  endtask

  task automatic check_now(input string tag);
    logic eh, em, ef;
    logic [31:0] ep, et;
    model_lookup(eh, em, ef, ep, et);
    checks++;
    if ({hit, miss, fault} !== {eh, em, ef} || pa !== ep || trap_va !== et) begin
      errors++;
      $display("FAIL %s: hmf=%b pa=%h trap=%h expected hmf=%b pa=%h trap=%h",
               tag, {hit, miss, fault}, pa, trap_va, {eh, em, ef}, ep, et);
    end
  endtask

  task automatic commit();
    @(posedge clk);
    if (flush) begin
      for (int i = 0; i < 64; i++) m_val[i] = 0;
    end else if (wr_en) begin
      m_val[wr_idx] = wr_valid; m_vpn[wr_idx] = wr_vpn; m_asid[wr_idx] = wr_asid;
      m_pfn[wr_idx] = wr_pfn; m_perm[wr_idx] = wr_perm;
    end
    if (asid_we) m_cur = asid_in;
    @(negedge clk);
  endtask

  task automatic step(input string tag);
    #3;
    check_now(tag);
    commit();
  endtask

  task automatic clear_ctl();
    wr_en = 0; flush = 0; asid_we = 0;
  endtask

  task automatic put(input int idx, input logic [19:0] vpn, input logic [5:0] asid,
                     input logic [19:0] pfn, input logic [5:0] perm);
    wr_en = 1; wr_idx = 6'(idx); wr_vpn = vpn; wr_asid = asid;
    wr_pfn = pfn; wr_perm = perm; wr_valid = 1;
  endtask

  task automatic look(input logic [31:0] va, input logic [1:0] acc, input logic sup);
    lk_valid = 1; lk_va = va; lk_acc = acc; lk_sup = sup;
  endtask

  initial begin
    #1200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    for (int i = 0; i < 64; i++) begin
      m_val[i] = 0; m_vpn[i] = 0; m_asid[i] = 0; m_pfn[i] = 0; m_perm[i] = 0;
    end
    m_cur = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R1: empty after reset
    look(32'h0000_1abc, 2'd0, 1'b1);
    step("R1 reset empty");

    // R8: write and lookup in the same cycle sees old contents
    put(3, 20'h00001, 6'd0, 20'h5a5a5, 6'b111111);
    step("R8 same-cycle old");
    clear_ctl();
    step("R8 next-cycle hit");
    // R2 hit with offset
    look(32'h0000_1fff, 2'd1, 1'b0);
    step("R2 user write hit");

    // R5 permission faults and reserved code
    put(4, 20'h00002, 6'd0, 20'h00777, 6'b000001);
    step("R5 setup");
    clear_ctl();
    look(32'h0000_2010, 2'd0, 1'b1); step("R5 sup read ok");
    look(32'h0000_2010, 2'd1, 1'b1); step("R5 sup write fault");
    look(32'h0000_2010, 2'd0, 1'b0); step("R5 user read fault");
    look(32'h0000_2010, 2'd3, 1'b1); step("R5 reserved fault");

    // R3 tag mismatch, tag register takes effect next cycle
    asid_we = 1; asid_in = 6'd9;
    look(32'h0000_1004, 2'd0, 1'b1);
    step("R3 old tag still hits");
    clear_ctl();
    step("R3 new tag misses");
    // R4 miss twice
    look(32'h0123_4567, 2'd2, 1'b1); step("R4 miss");
    step("R4 miss repeat");

    // R10 lowest index wins
    put(9, 20'h00040, 6'd9, 20'h99999, 6'b111111); step("R10 setup a");
    put(5, 20'h00040, 6'd9, 20'h55555, 6'b111111); step("R10 setup b");
    clear_ctl();
    look(32'h0004_0123, 2'd0, 1'b0); step("R10 low index");

    // R6 / R7 window
    look(32'h9234_5678, 2'd1, 1'b1); step("R6 window sup");
    look(32'h8000_0000, 2'd2, 1'b1); step("R6 window base");
    look(32'h9fff_ffff, 2'd0, 1'b0); step("R7 window user");

    // R9 flush beats write
    flush = 1;
    put(12, 20'h00050, 6'd9, 20'h12121, 6'b111111);
    look(32'h0004_0123, 2'd0, 1'b0);
    step("R9 pre-flush");
    clear_ctl();
    step("R9 flushed");
    look(32'h0005_0000, 2'd0, 1'b1); step("R9 write dropped");

    // R11 idle
    lk_valid = 0; step("R11 idle");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int r;
      clear_ctl();
      r = int'($urandom_range(0, 99));
      if (r < 3) flush = 1;
      else if (r < 40) begin
        put(int'($urandom_range(0, 63)), 20'h00100 + 20'($urandom_range(0, 7)),
            6'($urandom_range(0, 3)), 20'($urandom), 6'($urandom));
        wr_valid = ($urandom_range(0, 9) != 0);
      end
      if ($urandom_range(0, 19) == 0) begin asid_we = 1; asid_in = 6'($urandom_range(0, 3)); end
      lk_valid = ($urandom_range(0, 9) != 0);
      lk_acc = 2'($urandom);
      lk_sup = 1'($urandom);
      if ($urandom_range(0, 9) == 0) lk_va = {3'b100, 29'($urandom)};
      else lk_va = {20'h00100 + 20'($urandom_range(0, 7)), 12'($urandom)};
      if (!lk_valid) step("R11 random idle");
      else if (lk_va[31:29] == 3'b100) step(lk_sup ? "R6 random" : "R7 random");
      else step("R2 R3 R5 R10 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule